// File: doc/BRIEF.md
# Two-Channel Serial Setting Loader

This block receives write-only frames on a three-wire serial link (serial clock, active-low select, data) and keeps two 8-bit setting registers for a device with two channels. While select is low, each rising serial-clock edge shifts one data bit into an input register, most significant bit first. When select goes high again, the last nine bits received form a word. Its leading bit picks the channel and its lower eight bits become that channel's new setting.

The three serial lines are brought into the system clock domain through two-stage synchronizers, and edges are detected there. The system clock must run at least four times faster than the serial clock. Every channel presents its current setting and a strobe that is high for one system-clock cycle when that setting changes. A frame that holds fewer than nine bits is dropped. Serial-clock activity while select is high is ignored.

Top module: `spi_dual_setting_loader`

## Requirements
- R1: A synchronous reset sets both settings to mid-scale 0x80, drops both update strobes and empties the input register and the bit counter.
- R2: Bits are taken MSB first on rising serial-clock edges while csN is low. In the committed 9-bit word, bit 8 is the channel address and bits 7..0 are the setting value.
- R3: Address 0 writes channel A and address 1 writes channel B. The channel that is not addressed keeps its value.
- R4: A setting changes only after csN rises. While csN is still low after the shifting, both settings keep their earlier values.
- R5: If a frame carries more than nine bits, the leading surplus bits are dropped and only the last nine received are used.
- R6: A frame with fewer than nine bits updates no register and raises no strobe when csN rises.
- R7: Serial-clock edges while csN is high change neither the input register nor the bit count. A later short frame therefore still updates nothing.
- R8: Each channel's update strobe is high for exactly one system-clock cycle. That cycle is the first one in which the new value is visible, and a setting never changes without its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| csN | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data, MSB first |
| chanAValue | output | 8 | Setting of channel A (address 0) |
| chanBValue | output | 8 | Setting of channel B (address 1) |
| chanAUpdate | output | 1 | One-cycle strobe when channel A changes |
| chanBUpdate | output | 1 | One-cycle strobe when channel B changes |

## Verification
The bench sends frames of up to fourteen bits and checks the window before and after the select rise. A design that takes the first nine bits instead of the last nine writes garbage, or the wrong channel, on long frames. A design that commits partial words changes a setting on a short frame. A design that counts serial-clock edges while deselected lets a later four-bit frame commit. Strobes are checked against every observed value change, so an update that is early, late, doubled, or missing its strobe is reported.

// File: rtl/spi_loader_pkg.sv
package spi_loader_pkg;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic shiftBit;   // take one serial bit into the input register
    logic commit;     // a full word is present and the frame just closed
  } loaderCtrl_t;

endpackage

// File: rtl/spi_loader_sync.sv
module spi_loader_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stageQ;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (rst) stageQ <= RST_VAL;
        else     stageQ <= din;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (rst) stageQ <= {STAGES{RST_VAL}};
        else     stageQ <= {stageQ[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = stageQ[LAST];
endmodule

// File: rtl/spi_loader_ctrl.sv
module spi_loader_ctrl
  import spi_loader_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclkS,
  input  logic        csNS,
  output loaderCtrl_t strobes
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic sclkPrev;
  logic csPrev;
  logic [CNT_W-1:0] bitCount;
  logic sclkRise;
  logic csRise;

  assign sclkRise = sclkS & ~sclkPrev;
  assign csRise   = csNS & ~csPrev;

  always_comb begin
    strobes.shiftBit = sclkRise & ~csNS;
    strobes.commit   = csRise & (bitCount == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      bitCount <= '0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csNS;
      if (csRise)
        bitCount <= '0;
      else if (strobes.shiftBit && bitCount != FULL)
        bitCount <= bitCount + 1'b1;
    end
  end

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    bitCount <= FULL);

  assert_idle_edges_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (csNS && $past(csNS)) |=> $stable(bitCount));

  assert_short_frame_no_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (csRise && bitCount != FULL) |-> !strobes.commit);
endmodule

// File: rtl/spi_loader_dp.sv
module spi_loader_dp
  import spi_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << (DATA_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  loaderCtrl_t       strobes,
  input  logic              sdiS,
  output logic [DATA_W-1:0] valA,
  output logic [DATA_W-1:0] valB,
  output logic              updA,
  output logic              updB
);
  localparam int WORD_W = DATA_W + 1;
  localparam int NUM_CH = 2;

  logic [WORD_W-1:0] shiftReg;
  logic              addrBit;
  logic [DATA_W-1:0] dataField;
  logic [NUM_CH-1:0][DATA_W-1:0] chanVal;
  logic [NUM_CH-1:0] chanUpd;

  assign addrBit   = shiftReg[WORD_W-1];
  assign dataField = shiftReg[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                   shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {shiftReg[WORD_W-2:0], sdiS};
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gChan
      logic [DATA_W-1:0] valueQ;
      logic              updQ;
      logic              hit;
      assign hit = strobes.commit && (addrBit == g[0]);
      always_ff @(posedge clk) begin
        if (rst) begin
          valueQ <= RESET_VAL;
          updQ   <= 1'b0;
        end else begin
          updQ <= hit;
          if (hit) valueQ <= dataField;
        end
      end
      assign chanVal[g] = valueQ;
      assign chanUpd[g] = updQ;
    end
  endgenerate

  assign valA = chanVal[0];
  assign valB = chanVal[1];
  assign updA = chanUpd[0];
  assign updB = chanUpd[1];

  assert_one_channel_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chanUpd));

  assert_shift_only_selected_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftBit |=> $stable(shiftReg));
endmodule

// File: rtl/spi_dual_setting_loader.sv
module spi_dual_setting_loader
  import spi_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << (DATA_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdi,
  output logic [DATA_W-1:0] chanAValue,
  output logic [DATA_W-1:0] chanBValue,
  output logic              chanAUpdate,
  output logic              chanBUpdate
);
  localparam int WORD_W = DATA_W + 1;

  logic sclkS;
  logic csNS;
  logic sdiS;
  loaderCtrl_t strobes;

  spi_loader_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSyncClk (
    .clk(clk), .rst(rst), .din(sclk), .dout(sclkS));
  spi_loader_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSyncSel (
    .clk(clk), .rst(rst), .din(csN), .dout(csNS));
  spi_loader_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSyncDat (
    .clk(clk), .rst(rst), .din(sdi), .dout(sdiS));

  spi_loader_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst(rst), .sclkS(sclkS), .csNS(csNS), .strobes(strobes));

  spi_loader_dp #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .sdiS(sdiS),
    .valA(chanAValue), .valB(chanBValue),
    .updA(chanAUpdate), .updB(chanBUpdate));

  assert_other_holds_a_R3: assert property (@(posedge clk) disable iff (rst)
    chanAUpdate |-> $stable(chanBValue));
  assert_other_holds_b_R3: assert property (@(posedge clk) disable iff (rst)
    chanBUpdate |-> $stable(chanAValue));
  assert_change_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!chanAUpdate && !chanBUpdate && !$past(rst)) |->
      ($stable(chanAValue) && $stable(chanBValue)));
  assert_strobe_single_a_R8: assert property (@(posedge clk) disable iff (rst)
    chanAUpdate |=> !chanAUpdate);
  assert_strobe_single_b_R8: assert property (@(posedge clk) disable iff (rst)
    chanBUpdate |=> !chanBUpdate);
  assert_commit_after_select_R4: assert property (@(posedge clk) disable iff (rst)
    (chanAUpdate || chanBUpdate) |-> $past(csNS));
endmodule

// File: tb/spi_dual_setting_loader_test.sv
module spi_dual_setting_loader_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic [7:0] chanAValue, chanBValue;
  logic chanAUpdate, chanBUpdate;

  int checks = 0;
  int errors = 0;
  int updA = 0, updB = 0, silentChange = 0;
  logic [7:0] lastA, lastB, expA, expB;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_dual_setting_loader uut (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .sdi(sdi),
    .chanAValue(chanAValue), .chanBValue(chanBValue),
    .chanAUpdate(chanAUpdate), .chanBUpdate(chanBUpdate));

  always @(negedge clk) begin
    if (rst) begin
      lastA = chanAValue;
      lastB = chanBValue;
    end else begin
      if (chanAUpdate) updA++;
      if (chanBUpdate) updB++;
      if ((chanAValue !== lastA && !chanAUpdate) ||
          (chanBValue !== lastB && !chanBUpdate) ||
          (chanAUpdate && chanAValue === lastA && chanAValue !== expA) ||
          (chanBUpdate && chanBValue === lastB && chanBValue !== expB))
        silentChange++;
      lastA = chanAValue;
      lastB = chanBValue;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit isLong(input int n);
    return n >= 9;
  endfunction

  task automatic idleEdges(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) sdi = 1'($urandom);
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] bits, input int n, input string req);
    logic [7:0] newA, newB;
    int wantA, wantB;
    newA = expA; newB = expB; wantA = 0; wantB = 0;
    if (isLong(n)) begin
      if (bits[8]) begin newB = bits[7:0]; wantB = 1; end
      else         begin newA = bits[7:0]; wantA = 1; end
    end
    updA = 0; updB = 0; silentChange = 0;
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdi = bits[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    // R4: nothing moves while select is still low
    check(chanAValue == expA && chanBValue == expB && updA == 0 && updB == 0,
          {"R4 ", req}, {chanAValue, chanBValue}, {expA, expB});
    csN = 1'b1;
    expA = newA; expB = newB;
    repeat (12) @(negedge clk);
    check(chanAValue == expA, {"R2/R3 chanA ", req}, chanAValue, expA);
    check(chanBValue == expB, {"R2/R3 chanB ", req}, chanBValue, expB);
    check(updA == wantA && updB == wantB, {"R8 strobe count ", req},
          updA * 16 + updB, wantA * 16 + wantB);
    check(silentChange == 0, {"R8 strobe alignment ", req}, silentChange, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    expA = 8'h80; expB = 8'h80;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(chanAValue == 8'h80, "R1 chanA reset", chanAValue, 8'h80);
    check(chanBValue == 8'h80, "R1 chanB reset", chanBValue, 8'h80);
    check(!chanAUpdate && !chanBUpdate, "R1 strobes low", {chanAUpdate, chanBUpdate}, 0);

    sendFrame(16'h005A, 9, "addr0 basic");         // R2, R3
    sendFrame(16'h01C3, 9, "addr1 basic");         // R3
    sendFrame(16'h01FF, 9, "addr1 all ones");
    sendFrame(16'h0000, 9, "addr0 all zeros");
    sendFrame(16'h0E3C, 12, "R5 surplus leading"); // last nine = 0_3C
    sendFrame(16'h3F81, 14, "R5 surplus to B");    // last nine = 1_81
    sendFrame(16'h0015, 5, "R6 short frame");
    sendFrame(16'h00AA, 8, "R6 eight bits");
    idleEdges(9);                                   // R7
    sendFrame(16'h000B, 4, "R7 after idle edges");
    idleEdges(12);
    sendFrame(16'h0166, 9, "R7 full frame after idle");

    // R1 again mid-run: reset restores mid-scale
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expA = 8'h80; expB = 8'h80;
    @(negedge clk);
    check(chanAValue == 8'h80 && chanBValue == 8'h80, "R1 re-reset",
          {chanAValue, chanBValue}, 16'h8080);

    for (int f = 0; f < 40; f++) begin
      int n;
      logic [15:0] bits;
      n = 1 + int'($urandom_range(13));
      bits = 16'($urandom);
      if ($urandom_range(3) == 0) idleEdges(1 + int'($urandom_range(10)));
      sendFrame(bits, n, "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule